// File: doc/BRIEF.md
# System Clock Mode Controller

This block decides which clock the processor runs on. It selects between a fast main clock and a slow subclock, and from the selected source it produces a one-cycle instruction-cycle enable. Both oscillators appear as single-cycle tick enables on a common system clock. Software controls the block through one byte-wide register. Through that register it sets the main-clock speed divider and the stabilization wait length, and it asks for a mode change. It reads the same register to see which mode is live.

A switch to the subclock takes effect on the next clock. A switch to the main clock passes through a stabilization wait that counts main-oscillator ticks. The main clock is used only after that wait has run out. The block leaves reset in that wait, and the reset value of the wait length comes from a configuration input. A single-clock configuration pins the block to main mode.

The controller is a three-state machine:
- ST_SUB: running on the subclock.
- ST_WAIT: running on the subclock while the stabilization wait is counted.
- ST_MAIN: running on the main clock.

Its transitions are:
- T_REQ_MAIN (ST_SUB to ST_WAIT): the select bit is written 1.
- T_STABLE (ST_WAIT to ST_MAIN): the wait ends.
- T_ABORT (ST_WAIT to ST_SUB): the select bit is written 0.
- T_REQ_SUB (ST_MAIN to ST_SUB): the select bit is written 0.
- T_FORCE (any state to ST_MAIN): the single-clock configuration is set.

Register layout:

| Bit | Field | Access |
|-----|-------|--------|
| 7 | Mode monitor | Read-only |
| 6 | Unused | Reads 0 |
| 5 | Reserved | Reads 1 |
| 4:3 | Wait select | Read/write |
| 2 | Clock select | Read/write |
| 1:0 | Speed select | Read/write |

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset with single_clk_cfg=0, reg_rdata equals {1'b0, 1'b0, 1'b1, wait_opt, 1'b1, 2'b00}, and main_mode is 0 because the stabilization wait is running.
- R2: In main mode, cyc_en pulses once every 4, 8, 16 or 64 main ticks for speed select (bits 1:0) equal to 2'b11, 2'b10, 2'b01 or 2'b00.
- R3: Outside main mode, cyc_en pulses once every 2 sub ticks, whatever the value of the speed select.
- R4: Writing bit 2 = 1 in subclock mode starts a wait of 2^(4+4*W) main ticks, where W is bits 4:3. main_mode stays 0 during the wait and becomes 1 on the clock of the last tick.
- R5: Writing bit 2 = 0 makes main_mode 0 on the next clock, from main mode and also during a wait. An aborted wait never reaches main mode.
- R6: Writing the wait select while a wait is running does not change the length of that wait.
- R7: Bit 7 reads main_mode, and writes to it are ignored. Bit 6 always reads 0, and bit 5 always reads 1, whatever is written.
- R8: With single_clk_cfg=1, the block is in main mode from reset onward. Writing bit 2 has no effect, and bit 2 reads 1.
- R9: A speed-select change takes effect at the next cycle boundary. The period in progress completes at its old length.
- R10: cyc_en is never high on two consecutive clocks.
- R11: The wait counts only main ticks, and the speed select does not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | Main oscillator tick enable |
| sub_tick | input | 1 | Subclock tick enable |
| single_clk_cfg | input | 1 | Configuration: main clock only |
| wait_opt | input | 2 | Configuration: reset value of the wait select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cyc_en | output | 1 | Instruction-cycle enable pulse |
| main_mode | output | 1 | 1 when running on the main clock |

## Verification
The hardest cases to reach from the ports involve a wait that is already running: a wait-select write landing in the middle of it, and a subclock request aborting it. The stimulus reaches both with a counting loop. The loop injects a register write at a fixed cycle inside the wait and keeps counting until main_mode rises or a time limit passes. The speed-change boundary case is handled the same way. The bench first synchronizes to an enable pulse, then writes a few cycles into the next period and measures how long that period lasts. Throttling the main tick to every other cycle shows that the wait follows the oscillator ticks and not the system clock.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    typedef enum logic [1:0] {
        ST_SUB  = 2'd0,
        ST_WAIT = 2'd1,
        ST_MAIN = 2'd2
    } mode_e;

    // speed select to (main ticks per cycle) - 1
    function automatic logic [7:0] main_limit(input logic [1:0] spd);
        logic [7:0] lim;
        unique case (spd)
            2'b11:   lim = 8'd3;
            2'b10:   lim = 8'd7;
            2'b01:   lim = 8'd15;
            default: lim = 8'd63;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/sysclk_fsm.sv
module sysclk_fsm
    import sysclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  single,
    input  logic  req_main,
    input  logic  req_sub,
    input  logic  wait_done,
    output mode_e st,
    output logic  start_wait,
    output logic  main_mode
);

    mode_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= single ? ST_MAIN : ST_WAIT;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_SUB: begin
                if (single)        nxt = ST_MAIN;   // T_FORCE
                else if (req_main) nxt = ST_WAIT;   // T_REQ_MAIN
            end
            ST_WAIT: begin
                if (single)         nxt = ST_MAIN;  // T_FORCE
                else if (req_sub)   nxt = ST_SUB;   // T_ABORT
                else if (wait_done) nxt = ST_MAIN;  // T_STABLE
            end
            ST_MAIN: begin
                if (!single && req_sub) nxt = ST_SUB; // T_REQ_SUB
            end
            default: nxt = ST_SUB;
        endcase
    end

    // outputs
    always_comb begin
        start_wait = (st == ST_SUB) && req_main && !single;
        main_mode  = (st == ST_MAIN);
    end

endmodule

// File: rtl/stab_wait_timer.sv
module stab_wait_timer #(
    parameter int BASE_LOG = 4,
    parameter int STEP_LOG = 4,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rst_sel,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    input  logic             tick,
    output logic             done
);

    localparam int CNT_W = BASE_LOG + STEP_LOG * ((1 << SEL_W) - 1) + 1;

    logic [CNT_W-1:0] cnt;

    function automatic logic [CNT_W-1:0] wait_len(input logic [SEL_W-1:0] s);
        return CNT_W'(1) << (BASE_LOG + STEP_LOG * int'(s));
    endfunction

    // length is captured at start; later selector writes do not reach it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= wait_len(rst_sel);
        else if (start)              cnt <= wait_len(sel);
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = tick && (cnt == CNT_W'(1));

endmodule

// File: rtl/cyc_divider.sv
module cyc_divider
    import sysclk_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int SUB_RATIO = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_main,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic [1:0] spd,
    output logic       cyc_en
);

    localparam logic [CNT_W-1:0] SUB_LIM = CNT_W'(SUB_RATIO - 1);

    logic [CNT_W-1:0] cnt, lim_q, new_lim;
    logic             src_q, tick;

    always_comb begin
        tick    = src_main ? main_tick : sub_tick;
        new_lim = src_main ? CNT_W'(main_limit(spd)) : SUB_LIM;
    end

    // limit reloads only at a period boundary or on a source change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            lim_q  <= SUB_LIM;
            src_q  <= 1'b0;
            cyc_en <= 1'b0;
        end else begin
            cyc_en <= 1'b0;
            src_q  <= src_main;
            if (src_main != src_q) begin
                cnt   <= '0;
                lim_q <= new_lim;
            end else if (tick) begin
                if (cnt >= lim_q) begin
                    cnt    <= '0;
                    cyc_en <= 1'b1;
                    lim_q  <= new_lim;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
    import sysclk_pkg::*;
#(
    parameter int BASE_LOG  = 4,
    parameter int STEP_LOG  = 4,
    parameter int DIV_W     = 6,
    parameter int SUB_RATIO = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic       single_clk_cfg,
    input  logic [1:0] wait_opt,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       cyc_en,
    output logic       main_mode
);

    logic [1:0] spd_q, wsel_q;
    logic       sel_q;
    logic       req_main, req_sub, start_wait, wait_done;
    mode_e      st;
    logic       unused_wbits;

    assign unused_wbits = ^reg_wdata[7:5];
    assign req_main     = reg_we &&  reg_wdata[2];
    assign req_sub      = reg_we && !reg_wdata[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_q  <= 2'b00;
            wsel_q <= wait_opt;
            sel_q  <= 1'b1;
        end else begin
            if (reg_we) begin
                spd_q  <= reg_wdata[1:0];
                wsel_q <= reg_wdata[4:3];
            end
            if (single_clk_cfg) sel_q <= 1'b1;
            else if (reg_we)    sel_q <= reg_wdata[2];
        end
    end

    assign reg_rdata = {main_mode, 1'b0, 1'b1, wsel_q, sel_q, spd_q};

    sysclk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .single    (single_clk_cfg),
        .req_main  (req_main),
        .req_sub   (req_sub),
        .wait_done (wait_done),
        .st        (st),
        .start_wait(start_wait),
        .main_mode (main_mode)
    );

    stab_wait_timer #(
        .BASE_LOG(BASE_LOG),
        .STEP_LOG(STEP_LOG),
        .SEL_W   (2)
    ) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_sel(wait_opt),
        .start  (start_wait),
        .sel    (reg_wdata[4:3]),
        .tick   (main_tick),
        .done   (wait_done)
    );

    cyc_divider #(
        .CNT_W    (DIV_W),
        .SUB_RATIO(SUB_RATIO)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_main (main_mode),
        .main_tick(main_tick),
        .sub_tick (sub_tick),
        .spd      (spd_q),
        .cyc_en   (cyc_en)
    );

endmodule

// File: rtl/sysclk_mode_chk.sv
module sysclk_mode_chk
    import sysclk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       single_clk_cfg,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic       main_mode,
    input logic       cyc_en,
    input mode_e      st
);

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en |=> !cyc_en);

    // R8
    single_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_clk_cfg |-> main_mode);

    // R5
    to_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_wdata[2] && !single_clk_cfg) |=> !main_mode);

    // R4
    enter_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(main_mode) && !single_clk_cfg) |-> $past(st == ST_WAIT));

endmodule

bind sysclk_mode_ctrl sysclk_mode_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .single_clk_cfg(single_clk_cfg),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .main_mode     (main_mode),
    .cyc_en        (cyc_en),
    .st            (st)
);

// File: tb/sim_sysclk_mode_ctrl.sv
module sim_sysclk_mode_ctrl;

    localparam int CLK_P = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       main_tick = 1'b1, sub_tick = 1'b0;
    logic       single_clk_cfg = 1'b0;
    logic [1:0] wait_opt = 2'b00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cyc_en, main_mode;
    logic       main_gap = 1'b0;
    int         phase = 0;
    int         nchk = 0, nfail = 0;

    // speed select, expected period in clocks (main tick every clock)
    localparam logic [9:0] VEC [4] = '{
        {2'b11, 8'd4}, {2'b10, 8'd8}, {2'b01, 8'd16}, {2'b00, 8'd64}
    };

    sysclk_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
        .single_clk_cfg(single_clk_cfg), .wait_opt(wait_opt),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cyc_en(cyc_en), .main_mode(main_mode)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    // oscillator ticks: sub tick every 5 clocks
    initial forever begin
        @(negedge clk);
        phase++;
        sub_tick  = (phase % 5 == 0);
        main_tick = main_gap ? phase[0] : 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // clocks until the next enable pulse, optional write at cycle wr_at
    task automatic measure(output int n, input int wr_at, input logic [7:0] d);
        n = 0;
        do begin
            @(negedge clk);
            reg_we = 1'b0;
            n++;
            if (n == wr_at) begin reg_we = 1'b1; reg_wdata = d; end
        end while (!cyc_en && n < 2000);
    endtask

    // clocks until main_mode rises, optional write at cycle wr_at
    task automatic to_main(output int n, input int wr_at, input logic [7:0] d);
        n = 0;
        do begin
            @(negedge clk);
            reg_we = 1'b0;
            n++;
            if (n == wr_at) begin reg_we = 1'b1; reg_wdata = d; end
        end while (!main_mode && n < 2000);
    endtask

    task automatic period(output int n);
        int tmp;
        measure(tmp, -1, 8'h00);
        measure(tmp, -1, 8'h00);
        measure(n, -1, 8'h00);
    endtask

    initial begin
        #(CLK_P * 200000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        // R1 reset state
        idle(3);
        rst_n = 1'b1;
        chk(reg_rdata == 8'h24, "R1 reset rdata", reg_rdata, 8'h24);
        chk(main_mode == 1'b0, "R1 reset mode", main_mode, 0);
        to_main(n, -1, 8'h00);
        chk(n == 16, "R4 reset wait", n, 16);

        // R2 speed table, R10 pulse width
        for (int v = 0; v < 4; v++) begin
            wr(8'h24 | {6'd0, VEC[v][9:8]});
            period(n);
            chk(n == int'(VEC[v][7:0]), "R2 main period", n, VEC[v][7:0]);
            @(negedge clk);
            chk(cyc_en == 1'b0, "R10 pulse width", cyc_en, 0);
        end

        // R9 speed change mid period (currently /64)
        measure(n, -1, 8'h00);
        measure(n, 5, 8'h27);
        chk(n == 64, "R9 old period completes", n, 64);
        measure(n, -1, 8'h00);
        chk(n == 4, "R9 new period", n, 4);

        // R7 ignored bits in main mode
        wr(8'h47);
        chk(reg_rdata == 8'hA7, "R7 main readback", reg_rdata, 8'hA7);

        // R5, R3 subclock
        wr(8'h23);
        chk(main_mode == 1'b0, "R5 to sub", main_mode, 0);
        period(n);
        chk(n == 10, "R3 sub period fast spd", n, 10);
        wr(8'h20);
        period(n);
        chk(n == 10, "R3 sub period slow spd", n, 10);

        // R7 monitor write ignored in sub mode
        wr(8'h83);
        chk(reg_rdata == 8'h23, "R7 sub readback", reg_rdata, 8'h23);
        chk(main_mode == 1'b0, "R7 mode after bit7 write", main_mode, 0);

        // R4 wait length 16
        wr(8'h27);
        chk(main_mode == 1'b0, "R4 monitor in wait", main_mode, 0);
        to_main(n, -1, 8'h00);
        chk(n == 16, "R4 wait 16", n, 16);

        // R6 wait-select write during a 256-tick wait
        wr(8'h23);
        wr(8'h2F);
        to_main(n, 10, 8'h27);
        chk(n == 256, "R6 wait unchanged", n, 256);
        chk(reg_rdata == 8'hA7, "R6 readback", reg_rdata, 8'hA7);

        // R5 abort a wait
        wr(8'h23);
        wr(8'h2F);
        idle(5);
        wr(8'h2B);
        idle(300);
        chk(main_mode == 1'b0, "R5 aborted wait", main_mode, 0);
        chk(reg_rdata == 8'h2B, "R5 abort readback", reg_rdata, 8'h2B);

        // R11 wait follows main ticks only, slow speed select
        main_gap = 1'b1;
        wr(8'h24);
        to_main(n, -1, 8'h00);
        chk(n >= 30 && n <= 33, "R11 throttled wait", n, 32);
        main_gap = 1'b0;

        // R8 single-clock configuration
        @(negedge clk);
        rst_n = 1'b0;
        single_clk_cfg = 1'b1;
        idle(2);
        rst_n = 1'b1;
        chk(main_mode == 1'b1, "R8 main from reset", main_mode, 1);
        chk(reg_rdata == 8'hA4, "R8 reset rdata", reg_rdata, 8'hA4);
        wr(8'h23);
        chk(main_mode == 1'b1, "R8 select ignored", main_mode, 1);
        chk(reg_rdata == 8'hA7, "R8 select reads 1", reg_rdata, 8'hA7);
        period(n);
        chk(n == 4, "R8 main period", n, 4);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule